// File: doc/BRIEF.md
# Indexed-Write Batch Packer

This block turns a stream of register write requests into instructions in a command buffer memory. Each request carries a register offset, a data word and a kind bit, which selects either an indexed (auto-increment) write or a plain single write. A run of indexed requests to the same register is merged into one indexed-write instruction. The first request of a run writes a count word, a header word and the data word. Each later request in the run appends only its data word and raises the count word in place, through a read-modify-write on the buffer.

The block tracks two pointers in 32-bit words: the free position, where the next word goes, and the start of the current instruction. Every instruction begins on an even word. A word left over at an odd position after an indexed request is filled with zero, and the free position does not move past it. A single write also moves the start pointer, so a later indexed write to the same register cannot be merged into it. When the buffer is full, requests are dropped and a sticky overflow flag is raised. A synchronous clear empties the buffer pointers.

The buffer itself sits outside the block and is reached through a word write port and a word read port with one cycle of read latency.

Top module: `ipk_packer`

## Requirements
- R1: After reset, and in the cycle after `clear` is high, `free_pos` is 0, `overflow` is 0 and no indexed batch is open, so the next indexed request opens a new instruction at word 0. Buffer contents are not changed by clear.
- R2: An indexed request opens a new instruction when no indexed batch is open or its offset differs from the open batch's offset. The free position is first rounded up to even (p). Then the value 1 is written at p, the header {bits 31:24 = 0x09, bits 23:20 = 0, bits 19:0 = offset} at p+1 and the data at p+2. The free position becomes p+3, and p becomes the start of the new batch.
- R3: An indexed request whose offset equals the open batch's offset writes its data at the free position, advances it by one, and increments the count word at the batch start by one.
- R4: After an indexed request, if the free position is odd, a zero word is written there and the free position is left unchanged.
- R5: A single request rounds the free position up to even (p). It writes the data at p and the header {bits 31:24 = 0x01, bits 23:20 = 0xF, bits 19:0 = offset} at p+1, sets the free position to p+2 and closes any open indexed batch. A following indexed request to the same offset opens a new instruction.
- R6: A request accepted while the free position is at or above DEPTH writes nothing, leaves the free position unchanged and sets `overflow`.
- R7: `overflow` stays high until reset or clear.
- R8: `req_ready` is low from the cycle after an accepted non-dropped request until its words are written, and also while `clear` is high. Words whose position is at or above DEPTH are never written to the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous buffer clear |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_indexed | input | 1 | 1: indexed (batchable) write, 0: single write |
| req_addr | input | RW | Register offset |
| req_data | input | 32 | Data word |
| mem_we | output | 1 | Buffer word write enable |
| mem_waddr | output | $clog2(DEPTH) | Buffer write word address |
| mem_wdata | output | 32 | Buffer write data |
| mem_re | output | 1 | Buffer read enable |
| mem_raddr | output | $clog2(DEPTH) | Buffer read word address |
| mem_rdata | input | 32 | Buffer read data, valid one cycle after mem_re |
| free_pos | output | $clog2(DEPTH)+2 | Current free position in words |
| overflow | output | 1 | Sticky overflow indication |

## Verification
Some properties are checked by the embedded assertions on every cycle. They cover pointer reset on clear, even alignment of every new instruction start, the pad cycle leaving the free position alone, dropped requests not moving the pointer, the stickiness of the overflow flag, and merges only happening for the open batch's offset. The bench's scenarios show the rest by comparing the buffer image word by word against a behavioural model. That covers count words growing in place, header encodings, padding values, a single write breaking a batch, the new instruction opened after clear, and suppression of words that fall past the end of the buffer.

// File: rtl/ipk_pkg.sv
// Shared encodings for the indexed-write batch packer.
package ipk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CNT,
        ST_HDR,
        ST_SVAL,
        ST_DATA,
        ST_RD,
        ST_INC,
        ST_PAD
    } ipk_state_e;

    localparam logic [7:0] OPC_INDEXED = 8'h09;
    localparam logic [7:0] OPC_SINGLE  = 8'h01;
    localparam logic [3:0] BYTES_ALL   = 4'hF;
    localparam int         OFFS_W      = 20;
endpackage

// File: rtl/ipk_merge_check.sv
// Decides whether an incoming request extends the open indexed batch.
// Assumes cur_reg is only meaningful while batch_open is high.
module ipk_merge_check #(
    parameter int RW = 20
) (
    input  logic          batch_open,
    input  logic [RW-1:0] cur_reg,
    input  logic          req_indexed,
    input  logic [RW-1:0] req_addr,
    output logic          merge
);
    // Merge only an indexed request hitting the open batch's register.
    always_comb begin
        merge = batch_open && req_indexed && (req_addr == cur_reg);
    end
endmodule

// File: rtl/ipk_hdr_fmt.sv
// Builds the instruction header word for either instruction kind.
// Assumes RW is at most 20; narrower offsets are zero-extended.
module ipk_hdr_fmt
    import ipk_pkg::*;
#(
    parameter int RW = 20
) (
    input  logic          single,
    input  logic [RW-1:0] reg_off,
    output logic [31:0]   hdr
);
    logic [OFFS_W-1:0] off_ext;

    generate
        if (RW == OFFS_W) begin : g_full
            assign off_ext = reg_off;
        end else begin : g_ext
            assign off_ext = {{(OFFS_W-RW){1'b0}}, reg_off};
        end
    endgenerate

    // Select opcode and byte-enable field by instruction kind.
    always_comb begin
        hdr = single ? {OPC_SINGLE, BYTES_ALL, off_ext}
                     : {OPC_INDEXED, 4'h0, off_ext};
    end
endmodule

// File: rtl/ipk_ctrl.sv
// Sequencer of the packer: accepts one request at a time, keeps the free
// and instruction-start pointers, and issues one buffer access per cycle.
// Assumes the buffer returns read data one cycle after a read request.
module ipk_ctrl
    import ipk_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int RW    = 20,
    parameter int PW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_indexed,
    input  logic [RW-1:0] req_addr,
    input  logic [31:0]   req_data,
    input  logic          merge,
    input  logic [31:0]   hdr_word,
    output logic          lat_single,
    output logic [RW-1:0] lat_reg,
    output logic [RW-1:0] cur_reg,
    output logic          batch_open,
    output logic          wr_req,
    output logic [PW-1:0] wr_addr,
    output logic [31:0]   wr_data,
    output logic          rd_req,
    output logic [PW-1:0] rd_addr,
    input  logic [31:0]   rd_data,
    output logic [PW-1:0] free_pos,
    output logic          overflow
);
    localparam logic [PW-1:0] LIMIT = PW'(DEPTH);
    localparam logic [PW-1:0] ONE   = PW'(1);

    ipk_state_e    state;
    logic [PW-1:0] fp;
    logic [PW-1:0] sp;
    logic [PW-1:0] fp_even;
    logic [31:0]   dat_q;
    logic          merging_q;
    logic          accept;
    logic          full;

    assign req_ready = (state == ST_IDLE) && !clear;
    assign accept    = req_valid && req_ready;
    assign full      = (fp >= LIMIT);
    assign fp_even   = fp + {{(PW-1){1'b0}}, fp[0]};
    assign free_pos  = fp;

    // Sequence state, pointers and latched request.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            state      <= ST_IDLE;
            fp         <= '0;
            sp         <= '0;
            batch_open <= 1'b0;
            overflow   <= 1'b0;
            cur_reg    <= '0;
            lat_reg    <= '0;
            lat_single <= 1'b0;
            dat_q      <= '0;
            merging_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (full) begin
                            overflow <= 1'b1;
                        end else begin
                            dat_q      <= req_data;
                            lat_reg    <= req_addr;
                            lat_single <= !req_indexed;
                            merging_q  <= merge;
                            if (!req_indexed) begin
                                fp         <= fp_even;
                                sp         <= fp_even;
                                batch_open <= 1'b0;
                                state      <= ST_SVAL;
                            end else if (merge) begin
                                state <= ST_DATA;
                            end else begin
                                fp         <= fp_even;
                                sp         <= fp_even;
                                cur_reg    <= req_addr;
                                batch_open <= 1'b1;
                                state      <= ST_CNT;
                            end
                        end
                    end
                end
                ST_CNT: begin
                    fp    <= fp + ONE;
                    state <= ST_HDR;
                end
                ST_SVAL: begin
                    fp    <= fp + ONE;
                    state <= ST_HDR;
                end
                ST_HDR: begin
                    fp    <= fp + ONE;
                    state <= lat_single ? ST_IDLE : ST_DATA;
                end
                ST_DATA: begin
                    fp <= fp + ONE;
                    if (merging_q) state <= ST_RD;
                    else           state <= fp[0] ? ST_IDLE : ST_PAD;
                end
                ST_RD: begin
                    state <= ST_INC;
                end
                ST_INC: begin
                    state <= fp[0] ? ST_PAD : ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Buffer access for the current sequence step.
    always_comb begin
        wr_req  = 1'b0;
        wr_addr = fp;
        wr_data = '0;
        rd_req  = 1'b0;
        rd_addr = sp;
        case (state)
            ST_CNT:  begin wr_req = 1'b1; wr_data = 32'd1;         end
            ST_HDR:  begin wr_req = 1'b1; wr_data = hdr_word;      end
            ST_SVAL: begin wr_req = 1'b1; wr_data = dat_q;         end
            ST_DATA: begin wr_req = 1'b1; wr_data = dat_q;         end
            ST_RD:   begin rd_req = 1'b1;                          end
            ST_INC:  begin wr_req = 1'b1; wr_addr = sp;
                           wr_data = rd_data + 32'd1;              end
            ST_PAD:  begin wr_req = 1'b1; wr_data = '0;            end
            default: begin end
        endcase
    end

    // R1: clear empties both pointers and the overflow flag.
    a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fp == '0 && sp == '0 && !overflow && !batch_open));

    // R2: a new instruction always starts on an even word at the start pointer.
    a_r2_open_even: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CNT) |-> (fp[0] == 1'b0 && sp == fp));

    // R3: a merge is only taken for the open batch's register.
    a_r3_merge_same_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !full && merge) |-> (batch_open && req_indexed && req_addr == cur_reg));

    // R4: the pad word does not move the free position.
    a_r4_pad_keeps_fp: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD && !clear) |=> $stable(fp));

    // R6: a dropped request leaves the pointer and the sequencer idle.
    a_r6_drop_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && full) |=> ($stable(fp) && state == ST_IDLE && overflow));

    // R7: overflow is sticky until clear.
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clear) |=> overflow);
endmodule

// File: rtl/ipk_packer.sv
// Top of the indexed-write batch packer. Wires the sequencer to the merge
// decision and header formatter, and suppresses buffer accesses that fall
// past the last word. Assumes DEPTH is even and at least 4.
module ipk_packer #(
    parameter int DEPTH = 32,
    parameter int RW    = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_indexed,
    input  logic [RW-1:0]            req_addr,
    input  logic [31:0]              req_data,
    output logic                     mem_we,
    output logic [$clog2(DEPTH)-1:0] mem_waddr,
    output logic [31:0]              mem_wdata,
    output logic                     mem_re,
    output logic [$clog2(DEPTH)-1:0] mem_raddr,
    input  logic [31:0]              mem_rdata,
    output logic [$clog2(DEPTH)+1:0] free_pos,
    output logic                     overflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 2;
    localparam logic [PW-1:0] LIMIT = PW'(DEPTH);

    logic          merge;
    logic [31:0]   hdr_word;
    logic          lat_single;
    logic [RW-1:0] lat_reg;
    logic [RW-1:0] cur_reg;
    logic          batch_open;
    logic          wr_req;
    logic [PW-1:0] wr_addr;
    logic [31:0]   wr_data;
    logic          rd_req;
    logic [PW-1:0] rd_addr;

    ipk_merge_check #(.RW(RW)) u_merge (
        .batch_open  (batch_open),
        .cur_reg     (cur_reg),
        .req_indexed (req_indexed),
        .req_addr    (req_addr),
        .merge       (merge)
    );

    ipk_hdr_fmt #(.RW(RW)) u_hdr (
        .single  (lat_single),
        .reg_off (lat_reg),
        .hdr     (hdr_word)
    );

    ipk_ctrl #(.DEPTH(DEPTH), .RW(RW), .PW(PW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_indexed (req_indexed),
        .req_addr    (req_addr),
        .req_data    (req_data),
        .merge       (merge),
        .hdr_word    (hdr_word),
        .lat_single  (lat_single),
        .lat_reg     (lat_reg),
        .cur_reg     (cur_reg),
        .batch_open  (batch_open),
        .wr_req      (wr_req),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .rd_data     (mem_rdata),
        .free_pos    (free_pos),
        .overflow    (overflow)
    );

    // Gate buffer accesses to positions inside the buffer.
    always_comb begin
        mem_we    = wr_req && (wr_addr < LIMIT);
        mem_waddr = wr_addr[AW-1:0];
        mem_wdata = wr_data;
        mem_re    = rd_req && (rd_addr < LIMIT);
        mem_raddr = rd_addr[AW-1:0];
    end

    // R8: a request is never taken while a sequence is in flight.
    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !overflow && free_pos < LIMIT) |=> !req_ready);
endmodule

// File: tb/tb_ipk_packer.sv
// Bench for ipk_packer: a behavioural model of the buffer and pointers is
// updated per accepted request and compared on every idle clock.
module tb_ipk_packer;
    localparam int D   = 32;
    localparam int RW  = 20;
    localparam int AW  = $clog2(D);
    localparam int PW  = AW + 2;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_indexed = 1'b0;
    logic [RW-1:0] req_addr = '0;
    logic [31:0]   req_data = '0;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [31:0]   mem_wdata;
    logic          mem_re;
    logic [AW-1:0] mem_raddr;
    logic [31:0]   mem_rdata = '0;
    logic [PW-1:0] free_pos;
    logic          overflow;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    bit in_flight = 1'b0;

    logic [31:0] bmem [D];
    logic [31:0] ref_mem [D];
    int  m_fp = 0, m_sp = 0, m_reg = 0;
    bit  m_open = 1'b0, m_ovf = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipk_packer #(.DEPTH(D), .RW(RW)) dut (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_indexed(req_indexed), .req_addr(req_addr), .req_data(req_data),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .free_pos(free_pos), .overflow(overflow)
    );

    // Buffer memory with one cycle read latency.
    always @(posedge clk) begin
        if (mem_we) bmem[mem_waddr] <= mem_wdata;
        if (mem_re) mem_rdata <= bmem[mem_raddr];
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of pointer and flag against the model while idle.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && !clear && !in_flight && !done) begin
            check(int'(free_pos) == m_fp, "R2 R3 R5 free_pos vs model", free_pos, m_fp);
            check(overflow == m_ovf, "R6 R7 overflow vs model", overflow, m_ovf);
        end
    end

    function automatic void mw(input int p, input logic [31:0] v);
        if (p < D) ref_mem[p] = v;
    endfunction

    function automatic void model_req(input bit idx, input int a, input logic [31:0] d);
        logic [19:0] a20 = a[19:0];
        if (m_fp >= D) begin
            m_ovf = 1'b1;
        end else if (idx) begin
            if (m_open && a == m_reg) begin
                mw(m_fp, d);
                m_fp++;
                if (m_sp < D) ref_mem[m_sp] = ref_mem[m_sp] + 32'd1;
            end else begin
                m_fp = (m_fp + 1) & ~1;
                m_sp = m_fp;
                mw(m_fp, 32'd1);
                mw(m_fp + 1, {8'h09, 4'h0, a20});
                mw(m_fp + 2, d);
                m_fp += 3;
                m_open = 1'b1;
                m_reg = a;
            end
            if (m_fp % 2 == 1) mw(m_fp, 32'd0);
        end else begin
            m_fp = (m_fp + 1) & ~1;
            m_sp = m_fp;
            mw(m_fp, d);
            mw(m_fp + 1, {8'h01, 4'hF, a20});
            m_fp += 2;
            m_open = 1'b0;
        end
    endfunction

    task automatic send(input bit idx, input int a, input logic [31:0] d);
        bit was_full;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        in_flight = 1'b1;
        was_full = (m_fp >= D);
        req_valid = 1'b1; req_indexed = idx; req_addr = a[RW-1:0]; req_data = d;
        @(posedge clk);
        #1;
        model_req(idx, a, d);
        @(negedge clk);
        req_valid = 1'b0;
        if (!was_full) check(req_ready == 1'b0, "R8 ready low while busy", req_ready, 0);
        while (!req_ready) @(negedge clk);
        in_flight = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b0, "R8 ready low during clear", req_ready, 0);
        @(posedge clk);
        #1;
        m_fp = 0; m_sp = 0; m_open = 1'b0; m_ovf = 1'b0;
        @(negedge clk);
        clear = 1'b0;
        @(negedge clk);
    endtask

    task automatic mem_check(input string tag);
        for (int i = 0; i < D; i++) begin
            check(bmem[i] === ref_mem[i], tag, bmem[i], ref_mem[i]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < D; i++) begin
            bmem[i] = 32'hA5A5_0000 + 32'(i);
            ref_mem[i] = 32'hA5A5_0000 + 32'(i);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(free_pos == '0, "R1 free_pos after reset", free_pos, 0);
        check(overflow == 1'b0, "R1 overflow after reset", overflow, 0);
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

        // R2: open batch at word 0, R4: padding at 3
        send(1'b1, 'h100, 32'h1111_0001);
        check(free_pos == 3, "R2 free_pos after open", free_pos, 3);
        check(bmem[1] == 32'h0900_0100, "R2 indexed header", bmem[1], 32'h0900_0100);
        check(bmem[0] == 32'd1, "R2 count starts at 1", bmem[0], 1);
        check(bmem[3] == 32'd0, "R4 pad word zero", bmem[3], 0);

        // R3: merges grow the count in place
        send(1'b1, 'h100, 32'h1111_0002);
        check(bmem[0] == 32'd2, "R3 count after merge", bmem[0], 2);
        check(bmem[3] == 32'h1111_0002, "R3 data appended", bmem[3], 32'h1111_0002);
        send(1'b1, 'h100, 32'h1111_0003);
        check(bmem[0] == 32'd3, "R3 count after second merge", bmem[0], 3);
        check(bmem[5] == 32'd0 && free_pos == 5, "R4 pad keeps free_pos", free_pos, 5);

        // R2: different offset opens new aligned batch
        send(1'b1, 'h200, 32'h2222_0001);
        check(bmem[6] == 32'd1 && bmem[7] == 32'h0900_0200, "R2 new batch aligned", bmem[7], 32'h0900_0200);

        // R5: single write breaks the batch for the same offset
        send(1'b0, 'h200, 32'h3333_0001);
        check(bmem[11] == 32'h01F0_0200, "R5 single header", bmem[11], 32'h01F0_0200);
        check(free_pos == 12, "R5 free_pos after single", free_pos, 12);
        send(1'b1, 'h200, 32'h2222_0002);
        check(bmem[12] == 32'd1, "R5 no merge after single", bmem[12], 1);
        mem_check("R2 R3 R4 R5 buffer image");

        // R1: clear, then same offset reopens at 0
        do_clear();
        check(free_pos == '0 && !overflow, "R1 clear state", free_pos, 0);
        send(1'b1, 'h200, 32'h4444_0000);
        check(bmem[0] == 32'd1 && bmem[1] == 32'h0900_0200, "R1 reopen after clear", bmem[0], 1);

        // R6, R7: fill with merges, then overflow
        for (int k = 1; k < 30; k++) send(1'b1, 'h200, 32'h4444_0000 + 32'(k));
        check(free_pos == 32, "R6 buffer filled", free_pos, 32);
        check(bmem[0] == 32'd30, "R3 long batch count", bmem[0], 30);
        send(1'b1, 'h200, 32'hDEAD_0001);
        check(overflow == 1'b1 && free_pos == 32, "R6 dropped request", overflow, 1);
        send(1'b0, 'h300, 32'hDEAD_0002);
        repeat (3) @(negedge clk);
        check(overflow == 1'b1, "R7 overflow sticky", overflow, 1);
        mem_check("R6 buffer untouched by dropped requests");

        // R8: instruction crossing the end is clipped
        do_clear();
        check(overflow == 1'b0, "R7 overflow cleared", overflow, 0);
        for (int k = 0; k < 7; k++) send(1'b1, 'h10 + k, 32'h5555_0000 + 32'(k));
        send(1'b0, 'h40, 32'h6666_0000);
        check(free_pos == 30, "R5 aligned single", free_pos, 30);
        send(1'b1, 'h50, 32'h7777_0000);
        check(free_pos == 33, "R8 free_pos past end", free_pos, 33);
        mem_check("R8 no write beyond buffer");
        send(1'b1, 'h50, 32'h7777_0001);
        check(overflow == 1'b1, "R6 overflow past end", overflow, 1);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule